// File: doc/BRIEF.md
# Bank-Scheduled SDRAM Transaction Pipeline

This block is the command-issuing core of an SDRAM controller. It sees one pending request per bank, already registered upstream. Each request carries a port tag, a row, a column, a write flag and write data. Scheduling is by bank rather than by port. Every other clock cycle is a launch slot, and in a launch slot any requesting bank that is not busy may start. When several banks qualify, the lowest-numbered one wins.

A started transaction moves through four short stages, each with one register set:

- **Open:** issues the row activation.
- **Column:** waits for the column slot, then issues the read or write with auto-precharge.
- **Mask:** counts out the CAS latency.
- **Latch:** marks the cycle in which read data is on the pins and names the port that should take it.

Column commands always fall on the cycles between launch slots. As a result, activations and column commands never collide on the command pins.

The address pins are driven from a single register. In every cycle except a launch, that register reloads from a holding register that was prepared one cycle earlier. The holding register contains one of three values:

- the column word just before a column command;
- the mode word just before the mode-load step of power-up;
- otherwise, a word with only bit 10 set.

The bit-10 word serves the precharge-all step. On an activation, the selected bank's row replaces the holding value. Before the first launch, a short power-up sequence issues a precharge-all and then a mode load.

Top module: `sdr_bank_pipe`

## Requirements
- R1: While reset is held, every output is inactive. The command is NOP, and ack, dq_oe, latch_valid and init_done are all 0. Commands are `{ras_n,cas_n,we_n}`: NOP=111, ACT=011, READ=101, WRITE=100, PRE=010, MRS=000.
- R2: Edges are counted from k=0, the first rising edge with reset low. The block issues PRE with address exactly 1<<10 at k=INIT_WAIT. It issues MRS with address CAS_LAT<<4 (CAS latency in bits 6:4, all other bits 0) at k=INIT_WAIT+2. init_done goes high at k=INIT_WAIT+4 and stays high. All other init cycles are NOP.
- R3: No ACT is issued before init_done. An ACT is issued only at edges k=INIT_WAIT+6+2j (j = 0, 1, 2, …), so two ACTs are never adjacent.
- R4: An ACT selects the lowest-numbered bank whose request is high and which is not busy. It drives that bank number on ba and that bank's row on addr.
- R5: ack carries a one-cycle, single-bit pulse at the position of the launched bank, in the same cycle as the ACT. ack is 0 in every other cycle.
- R6: Once a bank has been activated at edge k, it is not activated again before edge k+BUSY_CYC+1.
- R7: Three cycles after each ACT, the block issues READ (write flag 0) or WRITE (write flag 1) to the same bank. The address is the column zero-extended, with bit 10 set for auto-precharge.
- R8: dq_oe is 1 exactly in WRITE command cycles. In those cycles dq carries the write data of that transaction.
- R9: latch_valid is high for one cycle, CAS_LAT cycles after each READ command cycle, with latch_port equal to that transaction's port tag. Writes never raise latch_valid.
- R10: If any requesting bank is not busy at a launch slot, an ACT is issued in that slot.
- R11: After init, every cycle that carries neither an ACT nor a column command carries NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NB | Per-bank request, held until acknowledged |
| req_port_i | input | NB*PORT_W | Per-bank port tag |
| req_row_i | input | NB*ROW_W | Per-bank row address |
| req_col_i | input | NB*COL_W | Per-bank column address |
| req_we_i | input | NB | Per-bank write flag |
| req_wdata_i | input | NB*DATA_W | Per-bank write data |
| ack_o | output | NB | One-cycle acceptance pulse per bank |
| cmd_o | output | 3 | SDRAM command `{ras_n,cas_n,we_n}` |
| ba_o | output | log2(NB) | SDRAM bank address |
| addr_o | output | ROW_W | SDRAM address pins |
| dq_o | output | DATA_W | Write data to the pins |
| dq_oe_o | output | 1 | Write data output enable |
| latch_valid_o | output | 1 | Read data is on the pins this cycle |
| latch_port_o | output | PORT_W | Port that should capture the read data |
| init_done_o | output | 1 | Power-up sequence complete |

## Verification
The bench builds the block with BUSY_CYC=5, INIT_WAIT=6 and CAS_LAT=2, and leaves the other parameters at their defaults. The short busy time lets a bank become eligible again after only three launch slots. That brings the boundary of the busy window, and repeated relaunch of one bank, into frequent reach. The short init wait reaches the first launch slot within a dozen edges, while requests that were raised during reset are still pending. Full-load phases keep all four banks contending, so lowest-bank priority and busy blocking are exercised together with column commands interleaved between the launches.

// File: rtl/sdr_pipe_pkg.sv
package sdr_pipe_pkg;
  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_NOP = 3'b111
  } sdr_cmd_e;

  // Address bit that requests auto-precharge / precharge of all banks
  localparam int AP_BIT = 10;
  // Position of the CAS latency field inside the mode word
  localparam int MODE_CL_LSB = 4;
endpackage

// File: rtl/sdr_init_seq.sv
module sdr_init_seq #(
  parameter int INIT_WAIT = 16
) (
  input  logic clk,
  input  logic rst,
  output logic init_done_o,
  output logic pre_due_o,
  output logic mrs_due_o,
  output logic mrs_next_o
);
  localparam int LAST = INIT_WAIT + 4;
  localparam int CW   = $clog2(LAST + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q       <= '0;
      init_done_o <= 1'b0;
    end else if (!init_done_o) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(LAST)) init_done_o <= 1'b1;
    end
  end

  // Step strobes: evaluated at the edge that issues the command
  assign pre_due_o  = !init_done_o && (cnt_q == CW'(INIT_WAIT));
  assign mrs_next_o = !init_done_o && (cnt_q == CW'(INIT_WAIT + 1));
  assign mrs_due_o  = !init_done_o && (cnt_q == CW'(INIT_WAIT + 2));

  AST_MRS_AFTER_PRE: assert property (@(posedge clk) disable iff (rst)
    mrs_due_o |-> $past(pre_due_o, 2)); // R2
endmodule

// File: rtl/sdr_bank_timer.sv
module sdr_bank_timer #(
  parameter int BUSY_CYC = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o
);
  localparam int TW = $clog2(BUSY_CYC + 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (start_i)       cnt_q <= TW'(BUSY_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
    start_i |-> !busy_o); // R6
endmodule

// File: rtl/sdr_bank_pick.sv
module sdr_bank_pick #(
  parameter int NB = 4,
  parameter int BW = 2
) (
  input  logic [NB-1:0] cand_i,
  output logic          any_o,
  output logic [BW-1:0] idx_o
);
  // Scan from the top so the lowest candidate is written last and wins
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        any_o = 1'b1;
        idx_o = BW'(i);
      end
    end
  end
endmodule

// File: rtl/sdr_bank_pipe.sv
module sdr_bank_pipe
  import sdr_pipe_pkg::*;
#(
  parameter int NB        = 4,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 9,
  parameter int DATA_W    = 16,
  parameter int PORT_W    = 3,
  parameter int BUSY_CYC  = 7,
  parameter int TRCD      = 2,
  parameter int CAS_LAT   = 2,
  parameter int INIT_WAIT = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NB-1:0]           req_i,
  input  logic [NB*PORT_W-1:0]    req_port_i,
  input  logic [NB*ROW_W-1:0]     req_row_i,
  input  logic [NB*COL_W-1:0]     req_col_i,
  input  logic [NB-1:0]           req_we_i,
  input  logic [NB*DATA_W-1:0]    req_wdata_i,
  output logic [NB-1:0]           ack_o,
  output logic [2:0]              cmd_o,
  output logic [$clog2(NB)-1:0]   ba_o,
  output logic [ROW_W-1:0]        addr_o,
  output logic [DATA_W-1:0]       dq_o,
  output logic                    dq_oe_o,
  output logic                    latch_valid_o,
  output logic [PORT_W-1:0]       latch_port_o,
  output logic                    init_done_o
);
  localparam int BANK_W = $clog2(NB);
  localparam int ADDR_W = ROW_W;
  // Column commands sit on the odd slots between launches: TRCD rounded up to odd.
  // Supported TRCD is 2..3, giving a 3-cycle ACT-to-column spacing.
  localparam int CAS_OFS  = (TRCD % 2 == 1) ? TRCD : TRCD + 1;
  localparam int CAS_WAIT = CAS_OFS - 2;
  localparam logic [ADDR_W-1:0] AP_WORD   = ADDR_W'(1) << AP_BIT;
  localparam logic [ADDR_W-1:0] MODE_WORD = ADDR_W'(CAS_LAT) << MODE_CL_LSB;

  // ---------------- power-up sequence ----------------
  logic init_done, pre_due, mrs_due, mrs_next;

  sdr_init_seq #(.INIT_WAIT(INIT_WAIT)) u_init (
    .clk(clk), .rst(rst), .init_done_o(init_done),
    .pre_due_o(pre_due), .mrs_due_o(mrs_due), .mrs_next_o(mrs_next)
  );
  assign init_done_o = init_done;

  // ---------------- launch slot and bank choice ----------------
  logic              phase_q;
  logic [NB-1:0]     busy, cand;
  logic              launch;
  logic [BANK_W-1:0] sel;

  always_ff @(posedge clk) begin
    if (rst)            phase_q <= 1'b0;
    else if (init_done) phase_q <= ~phase_q;
  end

  assign cand = req_i & ~busy & {NB{init_done & phase_q}};

  sdr_bank_pick #(.NB(NB), .BW(BANK_W)) u_pick (
    .cand_i(cand), .any_o(launch), .idx_o(sel)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    sdr_bank_timer #(.BUSY_CYC(BUSY_CYC)) u_tmr (
      .clk(clk), .rst(rst),
      .start_i(launch && (sel == BANK_W'(b))),
      .busy_o(busy[b])
    );
  end

  logic [ROW_W-1:0]  sel_row;
  logic [COL_W-1:0]  sel_col;
  logic [PORT_W-1:0] sel_port;
  logic [DATA_W-1:0] sel_wd;
  logic              sel_we;

  always_comb begin
    sel_row  = req_row_i[sel*ROW_W +: ROW_W];
    sel_col  = req_col_i[sel*COL_W +: COL_W];
    sel_port = req_port_i[sel*PORT_W +: PORT_W];
    sel_wd   = req_wdata_i[sel*DATA_W +: DATA_W];
    sel_we   = req_we_i[sel];
  end

  // ---------------- open (RAS) stage ----------------
  logic              ras_v;
  logic [BANK_W-1:0] ras_bank;
  logic [COL_W-1:0]  ras_col;
  logic [PORT_W-1:0] ras_port;
  logic [DATA_W-1:0] ras_wd;
  logic              ras_we;

  always_ff @(posedge clk) begin
    if (rst) ras_v <= 1'b0;
    else     ras_v <= launch;
    if (launch) begin
      ras_bank <= sel;
      ras_col  <= sel_col;
      ras_port <= sel_port;
      ras_wd   <= sel_wd;
      ras_we   <= sel_we;
    end
  end

  // ---------------- column (CAS) stage ----------------
  logic              cas_v, cas_wait;
  logic [BANK_W-1:0] cas_bank;
  logic [COL_W-1:0]  cas_col;
  logic [PORT_W-1:0] cas_port;
  logic [DATA_W-1:0] cas_wd;
  logic              cas_we;
  logic              issue;

  assign issue = cas_v && !cas_wait;

  always_ff @(posedge clk) begin
    if (rst) begin
      cas_v    <= 1'b0;
      cas_wait <= 1'b0;
    end else if (ras_v) begin
      cas_v    <= 1'b1;
      cas_wait <= (CAS_WAIT != 0);
    end else if (cas_wait) begin
      cas_wait <= 1'b0;
    end else begin
      cas_v    <= 1'b0;
    end
    if (ras_v) begin
      cas_bank <= ras_bank;
      cas_col  <= ras_col;
      cas_port <= ras_port;
      cas_wd   <= ras_wd;
      cas_we   <= ras_we;
    end
  end

  // ---------------- mask and latch stages ----------------
  logic              mask_v, mask_rd;
  logic [1:0]        mask_cnt;
  logic [PORT_W-1:0] mask_port;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_v        <= 1'b0;
      mask_cnt      <= '0;
      latch_valid_o <= 1'b0;
      latch_port_o  <= '0;
    end else begin
      latch_valid_o <= mask_v && mask_rd && (mask_cnt == '0);
      if (mask_v && (mask_cnt == '0)) latch_port_o <= mask_port;
      if (issue) begin
        mask_v   <= 1'b1;
        mask_cnt <= 2'(CAS_LAT - 1);
      end else if (mask_v) begin
        if (mask_cnt == '0) mask_v <= 1'b0;
        else                mask_cnt <= mask_cnt - 1'b1;
      end
    end
    if (issue) begin
      mask_rd   <= !cas_we;
      mask_port <= cas_port;
    end
  end

  // ---------------- holding register and pin registers ----------------
  logic [ADDR_W-1:0] hold_q;
  sdr_cmd_e          cmd_q;

  always_ff @(posedge clk) begin
    if (rst)                      hold_q <= AP_WORD;
    else if (cas_v && cas_wait)   hold_q <= ADDR_W'(cas_col) | AP_WORD;
    else if (mrs_next)            hold_q <= MODE_WORD;
    else                          hold_q <= AP_WORD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= CMD_NOP;
      ba_o    <= '0;
      addr_o  <= '0;
      ack_o   <= '0;
      dq_oe_o <= 1'b0;
      dq_o    <= '0;
    end else begin
      addr_o  <= launch ? sel_row : hold_q;
      ack_o   <= launch ? (NB'(1) << sel) : '0;
      dq_oe_o <= issue && cas_we;
      if (issue) dq_o <= cas_wd;
      if (launch)     ba_o <= sel;
      else if (issue) ba_o <= cas_bank;
      if (launch)       cmd_q <= CMD_ACT;
      else if (issue)   cmd_q <= cas_we ? CMD_WR : CMD_RD;
      else if (pre_due) cmd_q <= CMD_PRE;
      else if (mrs_due) cmd_q <= CMD_MRS;
      else              cmd_q <= CMD_NOP;
    end
  end

  assign cmd_o = cmd_q;

  // ---------------- assertions ----------------
  AST_NO_ACT_IN_INIT: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> (cmd_q != CMD_ACT)); // R3
  AST_ACT_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_ACT) |=> (cmd_q != CMD_ACT)); // R3
  AST_ACK_WITH_ACT: assert property (@(posedge clk) disable iff (rst)
    (|ack_o) |-> (cmd_q == CMD_ACT && $onehot0(ack_o) && ack_o[ba_o])); // R5
  AST_CAS_AFTER_ACT: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |->
      ($past(cmd_q, 3) == CMD_ACT && $past(ba_o, 3) == ba_o)); // R7
  AST_CAS_AUTOPRE: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> addr_o[AP_BIT]); // R7
  AST_MRS_WORD: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_MRS) |-> (addr_o == MODE_WORD)); // R2
  AST_WR_DRIVE: assert property (@(posedge clk) disable iff (rst)
    dq_oe_o |-> (cmd_q == CMD_WR)); // R8
  AST_LATCH_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
    latch_valid_o |-> ($past(cmd_q, CAS_LAT) == CMD_RD)); // R9
endmodule

// File: tb/sim_sdr_bank_pipe.sv
`timescale 1ns/1ps
module sim_sdr_bank_pipe;
  localparam int NB = 4, ROW_W = 13, COL_W = 9, DATA_W = 16, PORT_W = 3;
  localparam int BUSY = 5, TRCD = 2, CL = 2, IW = 6;
  localparam int CAS_OFS = (TRCD % 2 == 1) ? TRCD : TRCD + 1;
  localparam int BW = $clog2(NB);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst;
  logic [NB-1:0] rq;
  logic [ROW_W-1:0]  rrow [NB];
  logic [COL_W-1:0]  rcol [NB];
  logic [PORT_W-1:0] rport[NB];
  logic [DATA_W-1:0] rwd  [NB];
  logic              rwe  [NB];

  logic [NB*PORT_W-1:0] req_port;
  logic [NB*ROW_W-1:0]  req_row;
  logic [NB*COL_W-1:0]  req_col;
  logic [NB*DATA_W-1:0] req_wd;
  logic [NB-1:0]        req_we;

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      req_port[b*PORT_W +: PORT_W] = rport[b];
      req_row[b*ROW_W +: ROW_W]    = rrow[b];
      req_col[b*COL_W +: COL_W]    = rcol[b];
      req_wd[b*DATA_W +: DATA_W]   = rwd[b];
      req_we[b]                    = rwe[b];
    end
  end

  logic [NB-1:0] ack;
  logic [2:0] cmd;
  logic [BW-1:0] ba;
  logic [ROW_W-1:0] addr;
  logic [DATA_W-1:0] dq;
  logic dq_oe, lvalid, idone;
  logic [PORT_W-1:0] lport;

  sdr_bank_pipe #(.NB(NB), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .PORT_W(PORT_W), .BUSY_CYC(BUSY), .TRCD(TRCD), .CAS_LAT(CL), .INIT_WAIT(IW)) u0 (
    .clk(clk), .rst(rst), .req_i(rq), .req_port_i(req_port), .req_row_i(req_row),
    .req_col_i(req_col), .req_we_i(req_we), .req_wdata_i(req_wd), .ack_o(ack),
    .cmd_o(cmd), .ba_o(ba), .addr_o(addr), .dq_o(dq), .dq_oe_o(dq_oe),
    .latch_valid_o(lvalid), .latch_port_o(lport), .init_done_o(idone));

  localparam logic [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_RD = 3'b101,
                         C_WR = 3'b100, C_PRE = 3'b010, C_MRS = 3'b000;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  // schedules indexed by edge number modulo 8
  bit                cv [8];
  int                cb [8];
  logic [COL_W-1:0]  cc [8];
  bit                cw [8];
  logic [DATA_W-1:0] cd [8];
  logic [PORT_W-1:0] cp [8];
  bit                lv [8];
  logic [PORT_W-1:0] lp [8];
  int last_exp [NB];
  int last_obs [NB];
  int kk = 0;

  function automatic logic [ROW_W-1:0] col_word(logic [COL_W-1:0] c);
    return ROW_W'(c) | (ROW_W'(1) << 10);
  endfunction

  function automatic logic [ROW_W-1:0] mode_word();
    return ROW_W'(CL) << 4;
  endfunction

  function automatic bit is_slot(int k);
    return (k >= IW + 6) && (((k - IW) % 2) == 0);
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic raise(int b);
    rq[b]    = 1'b1;
    rrow[b]  = ROW_W'($urandom());
    rcol[b]  = COL_W'($urandom());
    rport[b] = PORT_W'($urandom());
    rwd[b]   = DATA_W'($urandom());
    rwe[b]   = ($urandom() % 2) == 1;
  endtask

  // One edge: check outputs produced at edge k, then drive inputs for k+1.
  task automatic step(int mode);
    int k;
    int win;
    logic [2:0] ecmd;
    k = kk;
    @(posedge clk);
    @(negedge clk);
    win = -1;
    ecmd = C_NOP;
    if (k == IW) ecmd = C_PRE;
    else if (k == IW + 2) ecmd = C_MRS;
    if (is_slot(k)) begin
      for (int b = NB - 1; b >= 0; b--)
        if (rq[b] && (k - last_exp[b] >= BUSY + 1)) win = b;
    end
    chk("R2", "init_done", 64'(idone), 64'(k >= IW + 4));
    if (win >= 0) begin
      ecmd = C_ACT;
      chk("R10", "launch cmd", 64'(cmd), 64'(C_ACT));
      chk("R4", "launch bank", 64'(ba), 64'(win));
      chk("R4", "launch row", 64'(addr), 64'(rrow[win]));
      chk("R5", "ack", 64'(ack), 64'(NB'(1) << win));
      last_exp[win] = k;
      cv[(k + CAS_OFS) % 8] = 1'b1;
      cb[(k + CAS_OFS) % 8] = win;
      cc[(k + CAS_OFS) % 8] = rcol[win];
      cw[(k + CAS_OFS) % 8] = rwe[win];
      cd[(k + CAS_OFS) % 8] = rwd[win];
      cp[(k + CAS_OFS) % 8] = rport[win];
    end else begin
      chk("R5", "ack idle", 64'(ack), 64'(0));
      if (cv[k % 8]) begin
        ecmd = cw[k % 8] ? C_WR : C_RD;
        chk("R7", "column cmd", 64'(cmd), 64'(ecmd));
        chk("R7", "column bank", 64'(ba), 64'(cb[k % 8]));
        chk("R7", "column word", 64'(addr), 64'(col_word(cc[k % 8])));
        if (cw[k % 8]) chk("R8", "write data", 64'(dq), 64'(cd[k % 8]));
        else begin
          lv[(k + CL) % 8] = 1'b1;
          lp[(k + CL) % 8] = cp[k % 8];
        end
        cv[k % 8] = 1'b0;
      end else if (ecmd == C_PRE) begin
        chk("R2", "precharge cmd", 64'(cmd), 64'(C_PRE));
        chk("R2", "precharge addr", 64'(addr), 64'(ROW_W'(1) << 10));
      end else if (ecmd == C_MRS) begin
        chk("R2", "mode cmd", 64'(cmd), 64'(C_MRS));
        chk("R2", "mode addr", 64'(addr), 64'(mode_word()));
      end else begin
        chk(k < IW + 4 ? "R3" : "R11", "idle cmd", 64'(cmd), 64'(C_NOP));
      end
    end
    chk("R8", "dq_oe", 64'(dq_oe), 64'(ecmd == C_WR));
    chk("R9", "latch_valid", 64'(lvalid), 64'(lv[k % 8]));
    if (lv[k % 8]) chk("R9", "latch_port", 64'(lport), 64'(lp[k % 8]));
    lv[k % 8] = 1'b0;
    if (cmd == C_ACT) begin
      chk("R3", "launch on slot", 64'(is_slot(k)), 64'(1));
      chk("R6", "busy spacing", 64'((k - last_obs[ba]) >= BUSY + 1), 64'(1));
      last_obs[ba] = k;
    end
    if (win >= 0) rq[win] = 1'b0;
    for (int b = 0; b < NB; b++) begin
      if (!rq[b]) begin
        if (mode == 1 && ($urandom() % 3) == 0) raise(b);
        if (mode == 2 && b == 3) raise(b);
        if (mode == 3) raise(b);
      end
    end
    kk++;
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) begin cv[i] = 0; lv[i] = 0; end
    for (int b = 0; b < NB; b++) begin
      last_exp[b] = -1000;
      last_obs[b] = -1000;
      raise(b);                 // all banks pending through reset and init (R3, R4)
    end
    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset cmd", 64'(cmd), 64'(C_NOP));
    chk("R1", "reset ack", 64'(ack), 64'(0));
    chk("R1", "reset dq_oe", 64'(dq_oe), 64'(0));
    chk("R1", "reset latch", 64'(lvalid), 64'(0));
    chk("R1", "reset init_done", 64'(idone), 64'(0));
    rst = 1'b0;
    for (int i = 0; i < IW + 40; i++) step(0);   // drain the four pending banks
    for (int i = 0; i < 2000; i++) step(1);      // random mixed load
    for (int i = 0; i < 400; i++) step(2);       // one bank hammered: busy boundary (R6)
    for (int i = 0; i < 1500; i++) step(3);      // full contention: lowest bank wins (R4)
    for (int i = 0; i < 1000; i++) step(1);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule